// File: doc/BRIEF.md
# No-Turnaround Synchronous Burst SRAM

This block is a small synchronous static memory. Its read and write commands share one address and control set and can follow each other on consecutive clock cycles, so the data bus never needs an idle cycle when the traffic changes direction. Every input is sampled on the rising clock edge. A write supplies its address first. Its data follows one cycle later in flow-through mode and two cycles later in pipelined mode, which matches the read latency of that mode. The write is stored when its data arrives.

A static mode pin selects the read timing. In pipelined mode the data passes through an output register. In flow-through mode the data comes straight from the array read stage. A command can start a four-beat burst, and the advance input then steps through the two low address bits in linear or interleaved order. Each 9-bit byte lane has its own write enable. Three chip enables of mixed polarity must all agree before a command is accepted. The output enable and the sleep input gate the output driver without waiting for a clock edge. The bus is modelled as a data vector plus a drive flag, with the data forced to zero when the flag is low.

Top module: `nbt_sram`

## Requirements
- R1: After a synchronous reset, dq_drive is low and dq_out is all zeros until a new read completes.
- R2: With pipe_mode=1, a read accepted at edge n drives its data from just after edge n+1 until edge n+2. Just after edge n it does not drive.
- R3: With pipe_mode=0, a read accepted at edge n drives its data from just after edge n until edge n+1.
- R4: The write data for a write accepted at edge n is sampled from wdata at edge n+2 when pipe_mode=1 and at edge n+1 when pipe_mode=0. The wdata value present with the command itself is not used.
- R5: Alternating read and write commands on consecutive edges, with no deselect between them, all complete with correct data.
- R6: Byte lane l occupies wdata and dq_out bits [9l+8:9l]. A write changes only the lanes whose lane_we bit was 1 when the command or burst beat was accepted. A write with lane_we=0 changes nothing.
- R7: With burst_ilv=0, each accepted edge with adv=1 continues the previous read or write burst. Beat k uses the address whose low two bits are (start+k) mod 4, and the upper bits are kept. An adv while no burst is active does nothing.
- R8: With burst_ilv=1, beat k uses the low two bits start XOR k, for both read and write bursts.
- R9: A new command is accepted only when en_lo_a=0, en_hi=1 and en_lo_b=0 (with adv=0). Otherwise no write takes place, no read is driven and any active burst ends.
- R10: oe=0 forces dq_drive low at once. Raising oe during the valid window of a read drives that read's data in the same cycle, without a clock edge.
- R11: sleep=1 forces dq_drive low at once. Commands sampled while sleep is high are dropped. Array contents are kept.
- R12: A read whose address has a write still pending returns the pending data in that write's enabled lanes and the earlier contents in the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| burst_ilv | input | 1 | Static: 1 interleaved burst order, 0 linear |
| en_lo_a | input | 1 | Chip enable, active low |
| en_hi | input | 1 | Chip enable, active high |
| en_lo_b | input | 1 | Chip enable, active low |
| wr | input | 1 | Command type: 1 write, 0 read |
| adv | input | 1 | Continue the current burst instead of a new command |
| lane_we | input | LANES (4) | Per-lane write enables, active high |
| addr | input | ADDR_W (8) | Word address |
| wdata | input | LANES*LANE_W (36) | Late write data |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous power-down, active high |
| dq_out | output | LANES*LANE_W (36) | Read data, zero when not driven |
| dq_drive | output | 1 | High when the data bus is driven |

## Verification
A stale pending-write entry or a wrong forwarding decision shows up as a wrong lane in the first read that follows the write, within two or three cycles. The bench therefore reads back right behind each write, in both modes, with partial lane masks. A burst counter or base register that goes wrong first appears on the second beat, so every burst is read beat by beat from a start value where linear and interleaved orders differ. A wrong latency or valid register changes the cycle in which dq_drive rises, so that flag is sampled one cycle early, in the expected cycle and one cycle late.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;

  // the burst walks through the two low address bits
  localparam int BURST_BITS = 2;

  typedef logic [BURST_BITS-1:0] beat_t;

  // low address bits for beat number 'step' of a burst that began at 'start'
  function automatic beat_t beat_addr(input beat_t start, input beat_t step, input logic ilv);
    beat_t r;
    if (ilv) r = start ^ step;
    else     r = beat_t'(start + step);
    return r;
  endfunction

endpackage

// File: rtl/nbt_lane_ram.sv
module nbt_lane_ram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wd,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // simple dual port, registered read, old data on collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wd;
    rd <= mem[raddr];
  end

endmodule

// File: rtl/nbt_cmd_seq.sv
module nbt_cmd_seq
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              burst_ilv,
  input  logic              adv,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we,
  output logic              iss_valid,
  output logic              iss_write,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [LANES-1:0]  iss_be
);
  logic              run_q;
  logic              run_wr_q;
  logic [ADDR_W-1:0] base_q;
  beat_t             cnt_q;
  beat_t             cnt_nxt;

  assign cnt_nxt = cnt_q + beat_t'(1);

  // operation issued at the current edge
  always_comb begin
    iss_valid = 1'b0;
    iss_write = 1'b0;
    iss_addr  = addr;
    iss_be    = lane_we;
    if (!sleep) begin
      if (adv) begin
        if (run_q) begin
          iss_valid = 1'b1;
          iss_write = run_wr_q;
          iss_addr  = {base_q[ADDR_W-1:BURST_BITS],
                       beat_addr(base_q[BURST_BITS-1:0], cnt_nxt, burst_ilv)};
        end
      end else if (sel) begin
        iss_valid = 1'b1;
        iss_write = wr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      run_wr_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (sleep) begin
      run_q <= 1'b0;
    end else if (adv) begin
      if (run_q) cnt_q <= cnt_nxt;
    end else if (sel) begin
      run_q    <= 1'b1;
      run_wr_q <= wr;
      base_q   <= addr;
      cnt_q    <= '0;
    end else begin
      run_q <= 1'b0;
    end
  end

endmodule

// File: rtl/nbt_late_write.sv
module nbt_late_write #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_mode,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [LANES-1:0]  push_be,
  output logic              cm_en,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [LANES-1:0]  cm_be,
  output logic              nx_valid,
  output logic [ADDR_W-1:0] nx_addr,
  output logic [LANES-1:0]  nx_be
);
  // maximum data lag of a write, in cycles
  localparam int STAGES = 2;

  logic [STAGES-1:0] v_q;
  logic [ADDR_W-1:0] a_q  [STAGES];
  logic [LANES-1:0]  be_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else begin
      v_q[0] <= push;
      for (int s = 1; s < STAGES; s++) v_q[s] <= pipe_mode & v_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    a_q[0]  <= push_addr;
    be_q[0] <= push_be;
    for (int s = 1; s < STAGES; s++) begin
      a_q[s]  <= a_q[s-1];
      be_q[s] <= be_q[s-1];
    end
  end

  // entry whose data is on wdata at this edge
  assign cm_en   = pipe_mode ? v_q[STAGES-1]  : v_q[0];
  assign cm_addr = pipe_mode ? a_q[STAGES-1]  : a_q[0];
  assign cm_be   = pipe_mode ? be_q[STAGES-1] : be_q[0];

  // pipelined mode only: entry whose data arrives at the next edge
  assign nx_valid = pipe_mode & v_q[0];
  assign nx_addr  = a_q[0];
  assign nx_be    = be_q[0];

endmodule

// File: rtl/nbt_read_path.sv
module nbt_read_path #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pipe_mode,
  input  logic                    oe,
  input  logic                    sleep,
  input  logic                    rd_req,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    cm_en,
  input  logic [ADDR_W-1:0]       cm_addr,
  input  logic [LANES-1:0]        cm_be,
  input  logic                    nx_valid,
  input  logic [ADDR_W-1:0]       nx_addr,
  input  logic [LANES-1:0]        nx_be,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES*LANE_W-1:0] mem_q,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_drive
);
  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0]  f1_be_q;
  logic [DATA_W-1:0] f1_data_q;
  logic [LANES-1:0]  f2_be_q;
  logic              rv1_q;
  logic              rv2_q;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] early;
  logic [DATA_W-1:0] late;

  always_ff @(posedge clk) begin
    if (rst) begin
      f1_be_q <= '0;
      f2_be_q <= '0;
      rv1_q   <= 1'b0;
      rv2_q   <= 1'b0;
    end else begin
      rv1_q   <= rd_req;
      rv2_q   <= pipe_mode & rv1_q;
      // write committing at the same edge: the array returns old data
      f1_be_q <= (rd_req && cm_en && cm_addr == rd_addr) ? cm_be : '0;
      // write whose data only shows up at the next edge
      f2_be_q <= (rd_req && nx_valid && nx_addr == rd_addr) ? nx_be : '0;
    end
  end

  always_ff @(posedge clk) begin
    f1_data_q <= wdata;
    out_q     <= late;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane_mux
    assign early[l*LANE_W +: LANE_W] = f1_be_q[l] ? f1_data_q[l*LANE_W +: LANE_W]
                                                  : mem_q[l*LANE_W +: LANE_W];
    assign late[l*LANE_W +: LANE_W]  = f2_be_q[l] ? wdata[l*LANE_W +: LANE_W]
                                                  : early[l*LANE_W +: LANE_W];
  end

  assign dq_drive = oe & ~sleep & (pipe_mode ? rv2_q : rv1_q);
  assign dq_out   = dq_drive ? (pipe_mode ? out_q : early) : '0;

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pipe_mode,
  input  logic                    burst_ilv,
  input  logic                    en_lo_a,
  input  logic                    en_hi,
  input  logic                    en_lo_b,
  input  logic                    wr,
  input  logic                    adv,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_drive
);
  localparam int DATA_W = LANES * LANE_W;

  logic              sel;
  logic              iss_valid;
  logic              iss_write;
  logic [ADDR_W-1:0] iss_addr;
  logic [LANES-1:0]  iss_be;
  logic              cm_en;
  logic [ADDR_W-1:0] cm_addr;
  logic [LANES-1:0]  cm_be;
  logic              nx_valid;
  logic [ADDR_W-1:0] nx_addr;
  logic [LANES-1:0]  nx_be;
  logic [DATA_W-1:0] mem_q;

  assign sel = ~en_lo_a & en_hi & ~en_lo_b;

  nbt_cmd_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk(clk), .rst(rst), .sleep(sleep), .burst_ilv(burst_ilv), .adv(adv),
    .sel(sel), .wr(wr), .addr(addr), .lane_we(lane_we),
    .iss_valid(iss_valid), .iss_write(iss_write), .iss_addr(iss_addr), .iss_be(iss_be)
  );

  nbt_late_write #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lw (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode),
    .push(iss_valid & iss_write), .push_addr(iss_addr), .push_be(iss_be),
    .cm_en(cm_en), .cm_addr(cm_addr), .cm_be(cm_be),
    .nx_valid(nx_valid), .nx_addr(nx_addr), .nx_be(nx_be)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    nbt_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
      .clk(clk),
      .we(cm_en & cm_be[l]),
      .waddr(cm_addr),
      .wd(wdata[l*LANE_W +: LANE_W]),
      .raddr(iss_addr),
      .rd(mem_q[l*LANE_W +: LANE_W])
    );
  end

  nbt_read_path #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep),
    .rd_req(iss_valid & ~iss_write), .rd_addr(iss_addr),
    .cm_en(cm_en), .cm_addr(cm_addr), .cm_be(cm_be),
    .nx_valid(nx_valid), .nx_addr(nx_addr), .nx_be(nx_be),
    .wdata(wdata), .mem_q(mem_q), .dq_out(dq_out), .dq_drive(dq_drive)
  );

endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
  parameter int HI_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            pipe_mode,
  input logic            oe,
  input logic            sleep,
  input logic            adv,
  input logic            en_lo_a,
  input logic            en_hi,
  input logic            en_lo_b,
  input logic            wr,
  input logic            dq_drive,
  input logic            iss_valid,
  input logic [HI_W-1:0] iss_hi
);
  logic en_ok;
  logic rd_cmd;

  assign en_ok  = !en_lo_a && en_hi && !en_lo_b;
  assign rd_cmd = !sleep && !adv && en_ok && !wr;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dq_drive);

  // R3
  flow_read_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && rd_cmd) |=> (dq_drive || !oe || sleep));

  // R2
  pipe_read_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && rd_cmd) |=> ##1 (dq_drive || !oe || sleep));

  // R9
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && !adv && !en_ok) |=> !dq_drive);

  // R11
  sleep_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && sleep) |=> !dq_drive);

  // R7
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && adv) |-> iss_hi == $past(iss_hi));

endmodule

bind nbt_sram nbt_sram_chk #(.HI_W(ADDR_W - nbt_sram_pkg::BURST_BITS)) u_chk (
  .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .oe(oe), .sleep(sleep), .adv(adv),
  .en_lo_a(en_lo_a), .en_hi(en_hi), .en_lo_b(en_lo_b), .wr(wr), .dq_drive(dq_drive),
  .iss_valid(iss_valid), .iss_hi(iss_addr[ADDR_W-1:nbt_sram_pkg::BURST_BITS])
);

// File: tb/test_nbt_sram.sv
module test_nbt_sram;
  localparam int DW = 36;

  typedef enum logic [1:0] {C_NOP, C_RD, C_WR, C_ADV} cmd_e;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pipe_mode = 1'b0;
  logic          burst_ilv = 1'b0;
  logic          en_lo_a = 1'b0;
  logic          en_hi = 1'b0;
  logic          en_lo_b = 1'b0;
  logic          wr = 1'b0;
  logic          adv = 1'b0;
  logic [3:0]    lane_we = '0;
  logic [7:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          oe = 1'b1;
  logic          sleep = 1'b0;
  logic [DW-1:0] dq_out;
  logic          dq_drive;

  int n_checks = 0;
  int n_fail = 0;
  int en_fault = 0;

  always #10 clk = ~clk;

  nbt_sram i_nbt_sram (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
    .en_lo_a(en_lo_a), .en_hi(en_hi), .en_lo_b(en_lo_b), .wr(wr), .adv(adv),
    .lane_we(lane_we), .addr(addr), .wdata(wdata), .oe(oe), .sleep(sleep),
    .dq_out(dq_out), .dq_drive(dq_drive)
  );

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic check_val(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v, input logic [DW-1:0] new_v,
                                          input logic [3:0] be);
    logic [DW-1:0] r = old_v;
    for (int l = 0; l < 4; l++) if (be[l]) r[l*9 +: 9] = new_v[l*9 +: 9];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(input logic [7:0] a);
    return {28'h5A5_C3E1, a};
  endfunction

  // present one command, then wait until the next falling edge
  task automatic step(input cmd_e c, input logic [7:0] a, input logic [3:0] be, input logic [DW-1:0] d);
    adv     = (c == C_ADV);
    wr      = (c == C_WR);
    en_hi   = (c == C_RD || c == C_WR) && en_fault != 2;
    en_lo_a = (en_fault == 1);
    en_lo_b = (en_fault == 3);
    addr    = a;
    lane_we = be;
    wdata   = d;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic pm, input logic ilv);
    rst = 1'b1;
    pipe_mode = pm;
    burst_ilv = ilv;
    step(C_NOP, 8'h00, 4'h0, '0);
    step(C_NOP, 8'h00, 4'h0, '0);
    rst = 1'b0;
  endtask

  task automatic preset(input logic [7:0] a, input logic [DW-1:0] d);
    step(C_WR, a, 4'hF, '0);
    if (pipe_mode) step(C_NOP, 8'h00, 4'h0, '0);
    step(C_NOP, 8'h00, 4'h0, d);
    step(C_NOP, 8'h00, 4'h0, '0);
  endtask

  task automatic read_expect(input string tag, input logic [7:0] a, input logic [DW-1:0] exp);
    step(C_RD, a, 4'h0, '0);
    if (pipe_mode) step(C_NOP, 8'h00, 4'h0, '0);
    check_bit(tag, dq_drive, 1'b1);
    check_val(tag, dq_out, exp);
    step(C_NOP, 8'h00, 4'h0, '0);
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b0);
    check_bit("R1 drive after reset", dq_drive, 1'b0);
    check_val("R1 data after reset", dq_out, '0);
  endtask

  task automatic t_flow_rw();
    do_reset(1'b0, 1'b0);
    step(C_WR, 8'h05, 4'hF, 36'h0_DEAD_BEEF);
    step(C_NOP, 8'h00, 4'h0, 36'h1_1111_2222);
    step(C_NOP, 8'h00, 4'h0, 36'hF_0F0F_0F0F);
    step(C_RD, 8'h05, 4'h0, '0);
    check_bit("R3 flow drive", dq_drive, 1'b1);
    check_val("R4 flow data lag one", dq_out, 36'h1_1111_2222);
    step(C_NOP, 8'h00, 4'h0, '0);
    check_bit("R3 flow window ends", dq_drive, 1'b0);
  endtask

  task automatic t_pipe_rw();
    do_reset(1'b1, 1'b0);
    step(C_WR, 8'h0A, 4'hF, 36'h0_AAAA_0001);
    step(C_NOP, 8'h00, 4'h0, 36'h0_AAAA_0002);
    step(C_NOP, 8'h00, 4'h0, 36'h3_3333_4444);
    step(C_NOP, 8'h00, 4'h0, '0);
    step(C_RD, 8'h0A, 4'h0, '0);
    check_bit("R2 pipe not yet", dq_drive, 1'b0);
    step(C_NOP, 8'h00, 4'h0, '0);
    check_bit("R2 pipe drive", dq_drive, 1'b1);
    check_val("R4 pipe data lag two", dq_out, 36'h3_3333_4444);
    step(C_NOP, 8'h00, 4'h0, '0);
    check_bit("R2 pipe window ends", dq_drive, 1'b0);
  endtask

  task automatic t_b2b();
    do_reset(1'b1, 1'b0);
    preset(8'h21, 36'h2_1212_1212);
    step(C_WR,  8'h20, 4'hF, '0);
    step(C_RD,  8'h21, 4'h0, '0);
    step(C_WR,  8'h22, 4'hF, 36'h2_0000_0020);
    check_bit("R5 first read drive", dq_drive, 1'b1);
    check_val("R5 first read", dq_out, 36'h2_1212_1212);
    step(C_RD,  8'h20, 4'h0, '0);
    step(C_RD,  8'h22, 4'h0, 36'h2_0000_0022);
    check_val("R5 read after write", dq_out, 36'h2_0000_0020);
    step(C_NOP, 8'h00, 4'h0, '0);
    check_val("R12 same-edge forward", dq_out, 36'h2_0000_0022);
    step(C_NOP, 8'h00, 4'h0, '0);
  endtask

  task automatic t_fwd();
    do_reset(1'b1, 1'b0);
    preset(8'h31, 36'h1_2345_6789);
    step(C_WR,  8'h31, 4'b0101, '0);
    step(C_RD,  8'h31, 4'h0, '0);
    step(C_NOP, 8'h00, 4'h0, 36'hE_DCBA_9876);
    check_bit("R12 pipe forward drive", dq_drive, 1'b1);
    check_val("R12 pipe late forward", dq_out,
              merge(36'h1_2345_6789, 36'hE_DCBA_9876, 4'b0101));
    step(C_NOP, 8'h00, 4'h0, '0);
    do_reset(1'b0, 1'b0);
    preset(8'h40, 36'h0_4040_4040);
    step(C_WR, 8'h40, 4'b1000, '0);
    step(C_RD, 8'h40, 4'h0, 36'hC_0FFE_E000);
    check_val("R12 flow forward", dq_out, merge(36'h0_4040_4040, 36'hC_0FFE_E000, 4'b1000));
    step(C_NOP, 8'h00, 4'h0, '0);
  endtask

  task automatic t_lanes();
    do_reset(1'b0, 1'b0);
    preset(8'h50, 36'h5_5555_5555);
    step(C_WR,  8'h50, 4'b0110, '0);
    step(C_NOP, 8'h00, 4'h0, 36'hA_AAAA_AAAA);
    step(C_NOP, 8'h00, 4'h0, '0);
    read_expect("R6 partial lanes", 8'h50, merge(36'h5_5555_5555, 36'hA_AAAA_AAAA, 4'b0110));
    step(C_WR,  8'h50, 4'b0000, '0);
    step(C_NOP, 8'h00, 4'h0, 36'h0_0000_0000);
    read_expect("R6 no lanes", 8'h50, merge(36'h5_5555_5555, 36'hA_AAAA_AAAA, 4'b0110));
  endtask

  task automatic t_burst_lin();
    do_reset(1'b0, 1'b0);
    for (int i = 4; i < 8; i++) preset(8'h40 + 8'(i), pat(8'h40 + 8'(i)));
    step(C_RD, 8'h45, 4'h0, '0);
    check_val("R7 beat0", dq_out, pat(8'h45));
    step(C_ADV, 8'h00, 4'h0, '0);
    check_val("R7 beat1", dq_out, pat(8'h46));
    step(C_ADV, 8'h00, 4'h0, '0);
    check_val("R7 beat2", dq_out, pat(8'h47));
    step(C_ADV, 8'h00, 4'h0, '0);
    check_val("R7 beat3 wraps", dq_out, pat(8'h44));
    step(C_NOP, 8'h00, 4'h0, '0);
    step(C_ADV, 8'h00, 4'h0, '0);
    check_bit("R7 adv without burst", dq_drive, 1'b0);
  endtask

  task automatic t_burst_ilv();
    do_reset(1'b0, 1'b1);
    step(C_WR,  8'h49, 4'hF, '0);
    step(C_ADV, 8'h00, 4'hF, pat(8'hE0));
    step(C_ADV, 8'h00, 4'hF, pat(8'hE1));
    step(C_ADV, 8'h00, 4'hF, pat(8'hE2));
    step(C_NOP, 8'h00, 4'h0, pat(8'hE3));
    read_expect("R8 write beat0", 8'h49, pat(8'hE0));
    read_expect("R8 write beat1", 8'h48, pat(8'hE1));
    step(C_RD, 8'h4B, 4'h0, '0);
    check_val("R8 read beat0", dq_out, pat(8'hE2));
    step(C_ADV, 8'h00, 4'h0, '0);
    check_val("R8 read beat1", dq_out, pat(8'hE3));
    step(C_ADV, 8'h00, 4'h0, '0);
    check_val("R8 read beat2", dq_out, pat(8'hE0));
    step(C_ADV, 8'h00, 4'h0, '0);
    check_val("R8 read beat3", dq_out, pat(8'hE1));
    step(C_NOP, 8'h00, 4'h0, '0);
  endtask

  task automatic t_select();
    do_reset(1'b0, 1'b0);
    preset(8'h70, 36'h7_7070_7070);
    for (int k = 1; k <= 3; k++) begin
      en_fault = k;
      step(C_WR, 8'h70, 4'hF, '0);
      en_fault = 0;
      step(C_NOP, 8'h00, 4'h0, 36'h9_9999_0000 + 36'(k));
      step(C_NOP, 8'h00, 4'h0, '0);
      read_expect("R9 write blocked", 8'h70, 36'h7_7070_7070);
    end
    en_fault = 2;
    step(C_RD, 8'h70, 4'h0, '0);
    en_fault = 0;
    check_bit("R9 read blocked", dq_drive, 1'b0);
    step(C_NOP, 8'h00, 4'h0, '0);
  endtask

  task automatic t_oe();
    do_reset(1'b0, 1'b0);
    preset(8'h80, 36'h8_0808_0808);
    oe = 1'b0;
    step(C_RD, 8'h80, 4'h0, '0);
    check_bit("R10 oe low", dq_drive, 1'b0);
    oe = 1'b1;
    #1;
    check_bit("R10 oe rise drive", dq_drive, 1'b1);
    check_val("R10 oe rise data", dq_out, 36'h8_0808_0808);
    step(C_NOP, 8'h00, 4'h0, '0);
  endtask

  task automatic t_sleep();
    do_reset(1'b0, 1'b0);
    preset(8'h90, 36'h9_0909_0909);
    step(C_RD, 8'h90, 4'h0, '0);
    check_bit("R11 awake drive", dq_drive, 1'b1);
    sleep = 1'b1;
    #1;
    check_bit("R11 sleep gates", dq_drive, 1'b0);
    step(C_WR,  8'h90, 4'hF, '0);
    step(C_NOP, 8'h00, 4'h0, 36'h6_6666_6666);
    step(C_RD,  8'h90, 4'h0, '0);
    check_bit("R11 read dropped", dq_drive, 1'b0);
    sleep = 1'b0;
    step(C_NOP, 8'h00, 4'h0, '0);
    read_expect("R11 contents kept", 8'h90, 36'h9_0909_0909);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_flow_rw();
    t_pipe_rw();
    t_b2b();
    t_fwd();
    t_lanes();
    t_burst_lin();
    t_burst_ilv();
    t_select();
    t_oe();
    t_sleep();
    report();
    $finish;
  end

endmodule